// File: doc/BRIEF.md
# Reset Qualifier with External-Access Strap Latch

This block sits between the raw active-high reset pin of a microcontroller core and the rest of the chip. The pin is resynchronised to the oscillator clock. It is then accepted as a reset only after it has been seen high for two complete machine cycles. A machine cycle is twelve oscillator clocks by default. The internal reset stays asserted while the pin is high. After the pin falls, the reset is held one more machine cycle and then removed.

The block also guards the external-access strap, which selects where code is fetched from. When the first lock bit is programmed, the strap is captured while the internal reset is active and is frozen once the reset ends. The frozen value then steers instruction fetch. It is also compared with the live pin, and any disagreement, including never having captured a value since power-up, raises a flag. When the lock bit is not programmed, the fetch source follows the live pin and the flag stays low.

The controller is a four-state machine:
- `ST_RUN`: no reset.
- `ST_QUAL`: counting high samples.
- `ST_HOLD`: reset asserted, pin still high.
- `ST_DRAIN`: reset asserted, counting low samples.

Its transitions:
- RUN→QUAL on the first high sample.
- QUAL→RUN on any low sample.
- QUAL→HOLD on the 24th consecutive high sample.
- HOLD→DRAIN on the first low sample.
- DRAIN→HOLD on any high sample.
- DRAIN→RUN on the 12th consecutive low sample.

Top module: `reset_qualifier`

## Requirements
- R1: While `por_n` is low and after it rises with the pins idle, `rst_int` is 0, and `strap_mismatch` is 0 while `lock1_prog` is 0.
- R2: The reset pin passes through a two-flop synchroniser. `rst_int` rises on the 26th rising clock edge after `rst_pin` goes high (2 synchroniser stages plus 24 consecutive high samples), and not before.
- R3: A high pulse lasting only 23 clock edges, or any run of high samples broken by a single low sample, never asserts `rst_int`. A low sample restarts the count from zero.
- R4: `rst_int` stays 1 while the pin is high. It falls on the 14th rising edge after `rst_pin` goes low (2 synchroniser stages plus 12 low samples). A high sample during this wait returns to holding, and the 12-sample wait starts over.
- R5: With `lock1_prog`=1, `strap_latched` takes the synchronised `ext_pin` level on every edge where `rst_int` is 1. It holds that value unchanged while `rst_int` is 0.
- R6: `strap_mismatch` is 1 exactly when all of the following hold: `lock1_prog`=1, `rst_int`=0, and either no capture has happened since `por_n` rose or `strap_latched` differs from the synchronised `ext_pin`. It is 0 during reset.
- R7: With `lock1_prog`=0, `strap_mismatch` is 0. `fetch_internal` equals `ext_pin` two edges later. A reset pulse leaves `strap_latched` unchanged.
- R8: `fetch_internal`=1 selects internal code memory and 0 selects external memory over the whole 0000h–FFFFh range. With `lock1_prog`=1 it follows `strap_latched`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-on reset from the supply monitor, active low |
| rst_pin | input | 1 | Raw reset pin, active high, asynchronous |
| ext_pin | input | 1 | External-access strap, high selects internal code |
| lock1_prog | input | 1 | First lock bit is programmed |
| rst_int | output | 1 | Qualified internal reset, active high |
| strap_latched | output | 1 | Strap value captured during the last reset |
| strap_mismatch | output | 1 | Captured strap disagrees with the live pin or was never captured |
| fetch_internal | output | 1 | 1 = fetch from internal memory, 0 = external |

## Verification
The assertions check several properties on every cycle:
- Each rise of `rst_int` is preceded by exactly 24 consecutive high samples, and each fall by exactly 12 low samples.
- A high sample never lets the reset drop.
- The captured strap never moves outside reset or while the lock bit is clear.

Only the bench's scenarios can show the exact edge counts from the pin, because they include the synchroniser latency. The same holds for the 23-versus-24 edge boundary, the bounce back into holding, and the mismatch and fetch-source values after a sequence of straps and resets.

// File: rtl/rstq_pkg.sv
package rstq_pkg;

    // Controller states of the reset qualifier.
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_QUAL  = 2'd1,
        ST_HOLD  = 2'd2,
        ST_DRAIN = 2'd3
    } rq_state_e;

endpackage

// File: rtl/rstq_sync.sv
module rstq_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/rstq_fsm.sv
module rstq_fsm
    import rstq_pkg::*;
#(
    parameter int MCYC_CLKS  = 12,
    parameter int QUAL_MCYC  = 2,
    parameter int REL_MCYC   = 1
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_s,
    output logic rst_int
);

    localparam int QUAL_N = MCYC_CLKS * QUAL_MCYC;
    localparam int REL_N  = MCYC_CLKS * REL_MCYC;
    localparam int MAX_N  = (QUAL_N > REL_N) ? QUAL_N : REL_N;
    localparam int CNT_W  = $clog2(MAX_N + 1);
    localparam logic [CNT_W-1:0] QUAL_LAST = CNT_W'(QUAL_N - 1);
    localparam logic [CNT_W-1:0] REL_LAST  = CNT_W'(REL_N - 1);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

    rq_state_e        state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    // Next-state and count decision.
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_RUN: begin
                if (rst_s) begin
                    state_nx = ST_QUAL;
                    cnt_nx   = ONE;
                end else begin
                    cnt_nx   = '0;
                end
            end
            ST_QUAL: begin
                if (!rst_s) begin
                    state_nx = ST_RUN;
                    cnt_nx   = '0;
                end else if (cnt == QUAL_LAST) begin
                    state_nx = ST_HOLD;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx   = cnt + ONE;
                end
            end
            ST_HOLD: begin
                if (!rst_s) begin
                    state_nx = ST_DRAIN;
                    cnt_nx   = ONE;
                end else begin
                    cnt_nx   = '0;
                end
            end
            ST_DRAIN: begin
                if (rst_s) begin
                    state_nx = ST_HOLD;
                    cnt_nx   = '0;
                end else if (cnt == REL_LAST) begin
                    state_nx = ST_RUN;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx   = cnt + ONE;
                end
            end
            default: begin
                state_nx = ST_RUN;
                cnt_nx   = '0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state <= ST_RUN;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // Outputs decoded from the registered state.
    always_comb begin
        unique case (state)
            ST_HOLD, ST_DRAIN: rst_int = 1'b1;
            default:           rst_int = 1'b0;
        endcase
    end

    // Independent run-length counters used by the checks below.
    logic [CNT_W-1:0] chk_hi, chk_lo;
    localparam logic [CNT_W-1:0] SAT = CNT_W'(MAX_N);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            chk_hi <= '0;
            chk_lo <= '0;
        end else begin
            chk_hi <= rst_s  ? ((chk_hi == SAT) ? SAT : chk_hi + ONE) : '0;
            chk_lo <= !rst_s ? ((chk_lo == SAT) ? SAT : chk_lo + ONE) : '0;
        end
    end

    AST_QUAL_LENGTH: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_int) |-> (chk_hi == CNT_W'(QUAL_N)));                    // R2

    AST_RELEASE_LENGTH: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_int) |-> (chk_lo == CNT_W'(REL_N)));                     // R4

    AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!por_n)
        (rst_int && rst_s) |=> rst_int);                                   // R4

    AST_LOW_BLOCKS_RISE: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_int && !rst_s) |=> !rst_int);                                // R3

endmodule

// File: rtl/rstq_strap.sv
module rstq_strap (
    input  logic clk,
    input  logic por_n,
    input  logic rst_int,
    input  logic lock1,
    input  logic ext_s,
    output logic strap_q,
    output logic mismatch,
    output logic fetch_int
);

    logic loaded;

    // Capture flop: deliberately not cleared, its power-up value is undefined.
    always_ff @(posedge clk) begin
        if (rst_int && lock1) begin
            strap_q <= ext_s;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            loaded <= 1'b0;
        end else if (rst_int && lock1) begin
            loaded <= 1'b1;
        end
    end

    always_comb begin
        if (lock1) begin
            fetch_int = strap_q;
            mismatch  = !rst_int && (!loaded || (strap_q != ext_s));
        end else begin
            fetch_int = ext_s;
            mismatch  = 1'b0;
        end
    end

    AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
        (!$past(rst_int) && loaded && $past(loaded)) |-> $stable(strap_q));  // R5

    AST_NOLOCK_KEEP: assert property (@(posedge clk) disable iff (!por_n)
        (!$past(lock1) && loaded && $past(loaded)) |-> $stable(strap_q));    // R7

    AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
        rst_int |-> !mismatch);                                              // R6

endmodule

// File: rtl/reset_qualifier.sv
module reset_qualifier #(
    parameter int MCYC_CLKS  = 12,
    parameter int QUAL_MCYC  = 2,
    parameter int REL_MCYC   = 1,
    parameter int SYNC_STAGE = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_pin,
    input  logic ext_pin,
    input  logic lock1_prog,
    output logic rst_int,
    output logic strap_latched,
    output logic strap_mismatch,
    output logic fetch_internal
);

    logic [1:0] pins_s;
    logic       rst_s, ext_s;

    rstq_sync #(.STAGES(SYNC_STAGE), .WIDTH(2)) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .d     ({ext_pin, rst_pin}),
        .q     (pins_s)
    );

    assign rst_s = pins_s[0];
    assign ext_s = pins_s[1];

    rstq_fsm #(
        .MCYC_CLKS (MCYC_CLKS),
        .QUAL_MCYC (QUAL_MCYC),
        .REL_MCYC  (REL_MCYC)
    ) u_fsm (
        .clk     (clk),
        .por_n   (por_n),
        .rst_s   (rst_s),
        .rst_int (rst_int)
    );

    rstq_strap u_strap (
        .clk       (clk),
        .por_n     (por_n),
        .rst_int   (rst_int),
        .lock1     (lock1_prog),
        .ext_s     (ext_s),
        .strap_q   (strap_latched),
        .mismatch  (strap_mismatch),
        .fetch_int (fetch_internal)
    );

    AST_NOLOCK_NO_FLAG: assert property (@(posedge clk) disable iff (!por_n)
        !lock1_prog |-> !strap_mismatch);                                  // R7

endmodule

// File: tb/tb_reset_qualifier.sv
module tb_reset_qualifier;

    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic por_n, rst_pin, ext_pin, lock1_prog;
    logic rst_int, strap_latched, strap_mismatch, fetch_internal;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    reset_qualifier dut (
        .clk            (clk),
        .por_n          (por_n),
        .rst_pin        (rst_pin),
        .ext_pin        (ext_pin),
        .lock1_prog     (lock1_prog),
        .rst_int        (rst_int),
        .strap_latched  (strap_latched),
        .strap_mismatch (strap_mismatch),
        .fetch_internal (fetch_internal)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pulse_reset();
        rst_pin = 1'b1;
        step(26);
        rst_pin = 1'b0;
        step(14);
    endtask

    task automatic t_reset_state();
        por_n = 1'b0; rst_pin = 1'b0; ext_pin = 1'b1; lock1_prog = 1'b0;
        step(3);
        chk("R1 rst_int in por", rst_int, 1'b0);
        por_n = 1'b1;
        step(4);
        chk("R1 rst_int idle", rst_int, 1'b0);
        chk("R1 mismatch idle", strap_mismatch, 1'b0);
        lock1_prog = 1'b1;
        step(1);
        chk("R6 never captured flags", strap_mismatch, 1'b1);
        lock1_prog = 1'b0;
        step(1);
    endtask

    task automatic t_short_pulse();
        logic seen = 1'b0;
        rst_pin = 1'b1;
        step(23);
        rst_pin = 1'b0;
        for (int i = 0; i < 30; i++) begin
            step(1);
            if (rst_int) seen = 1'b1;
        end
        chk("R3 23-edge pulse ignored", seen, 1'b0);
        seen = 1'b0;
        rst_pin = 1'b1; step(20);
        rst_pin = 1'b0; step(1);
        rst_pin = 1'b1; step(20);
        rst_pin = 1'b0;
        for (int i = 0; i < 30; i++) begin
            step(1);
            if (rst_int) seen = 1'b1;
        end
        chk("R3 broken run restarts", seen, 1'b0);
    endtask

    task automatic t_exact_qual();
        rst_pin = 1'b1;
        step(25);
        chk("R2 not yet at edge 25", rst_int, 1'b0);
        step(1);
        chk("R2 asserted at edge 26", rst_int, 1'b1);
        step(10);
        chk("R4 held while high", rst_int, 1'b1);
        rst_pin = 1'b0;
        step(13);
        chk("R4 still held at edge 13", rst_int, 1'b1);
        step(1);
        chk("R4 released at edge 14", rst_int, 1'b0);
    endtask

    task automatic t_min_pulse();
        rst_pin = 1'b1;
        step(24);
        rst_pin = 1'b0;
        step(2);
        chk("R2 24-edge pulse qualifies", rst_int, 1'b1);
        step(20);
        chk("R4 released after minimum pulse", rst_int, 1'b0);
    endtask

    task automatic t_drain_bounce();
        rst_pin = 1'b1; step(30);
        rst_pin = 1'b0; step(8);
        rst_pin = 1'b1; step(4);
        chk("R4 bounce keeps reset", rst_int, 1'b1);
        rst_pin = 1'b0;
        step(13);
        chk("R4 drain restarted", rst_int, 1'b1);
        step(1);
        chk("R4 release after restart", rst_int, 1'b0);
    endtask

    task automatic t_latch_lock();
        lock1_prog = 1'b1; ext_pin = 1'b1;
        step(3);
        rst_pin = 1'b1; step(26);
        chk("R6 quiet during reset", strap_mismatch, 1'b0);
        rst_pin = 1'b0; step(14);
        chk("R5 captured high", strap_latched, 1'b1);
        chk("R8 internal fetch", fetch_internal, 1'b1);
        chk("R6 agree no flag", strap_mismatch, 1'b0);
        ext_pin = 1'b0;
        step(2);
        chk("R6 disagreement flagged", strap_mismatch, 1'b1);
        chk("R8 fetch follows capture", fetch_internal, 1'b1);
        step(5);
        chk("R5 capture frozen", strap_latched, 1'b1);
        pulse_reset();
        chk("R5 recaptured low", strap_latched, 1'b0);
        chk("R8 external fetch", fetch_internal, 1'b0);
        chk("R6 agree after recapture", strap_mismatch, 1'b0);
    endtask

    task automatic t_nolock();
        logic held;
        lock1_prog = 1'b0;
        held = strap_latched;
        ext_pin = ~held;
        step(2);
        chk("R7 fetch follows pin", fetch_internal, ~held);
        chk("R7 no flag", strap_mismatch, 1'b0);
        ext_pin = held;
        step(2);
        chk("R7 fetch follows pin back", fetch_internal, held);
        ext_pin = ~held;
        step(2);
        pulse_reset();
        chk("R7 capture untouched", strap_latched, held);
        chk("R7 no flag after reset", strap_mismatch, 1'b0);
    endtask

    initial begin
        t_reset_state();
        t_short_pulse();
        t_exact_qual();
        t_min_pulse();
        t_drain_bounce();
        t_latch_lock();
        t_nolock();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule